// File: doc/BRIEF.md
# Serial Link Transmit Fill Controller

This block chooses, in every character slot, what a serial transmitter sends. The character comes from one of three places. It can be user data, taken either straight from a direct input port or from a transmit FIFO. It can be an idle code that the downstream 8b/10b encoder expands into a K28.5 comma. Or it can be a ready-made 10-bit K28.5 symbol, used when the encoder is switched off. Two mode straps select the data source and whether the encoder is in use. A halt request stops FIFO reads and forces idle fill until it is removed.

A one-hot-free slot state register holds the kind of character currently on the output bus. Its states are `SL_QUIET`, `SL_DIRECT`, `SL_QUEUE`, `SL_K_IDLE` and `SL_RAW_IDLE`:

- `SL_QUIET` is the state after reset.
- `SL_DIRECT` carries a direct-port data character.
- `SL_QUEUE` carries a FIFO data character.
- `SL_K_IDLE` carries an encoder idle code.
- `SL_RAW_IDLE` carries a pre-encoded idle symbol.

At every clock edge the state moves to the kind chosen from the straps, the halt request, the data-enable strobe and the FIFO empty flag. The transitions are:

- to an idle kind when halt is high;
- to `SL_DIRECT` when the FIFO is bypassed and the strobe is high;
- to `SL_QUEUE` when the FIFO is in use and not empty;
- to an idle kind otherwise.

The idle kind is `SL_RAW_IDLE` under encoder bypass and `SL_K_IDLE` otherwise. No transition returns to `SL_QUIET` except reset.

Pre-encoded idles alternate between the negative-disparity and positive-disparity K28.5 forms. A private toggle drives the alternation. It flips only after a slot that carried such a symbol, so the sequence resumes where it left off across data slots and mode changes.

Top module: `txfill_ctrl`

## Requirements
- R1: While reset is held and in the first slot after it, `char_o` is 0 and `ctrl_o` is 0.
- R2: With `fifo_bypass_i`=1, `halt_i`=0 and `data_en_i`=1, the slot after the edge shows the direct data with `ctrl_o`=0. The encoder-on form is `{2'b00, data_i[7:0]}`; under `enc_bypass_i`=1 all 10 bits of `data_i` pass through.
- R3: With the encoder on (`enc_bypass_i`=0), every idle slot shows `ctrl_o`=1 and `char_o`=0x0BC, the K28.5 special index. Every data slot shows `ctrl_o`=0.
- R4: With `enc_bypass_i`=1, idle slots show `ctrl_o`=0 and raw symbols. These alternate between 10'b0011111010 and 10'b1100000101, and the first after reset is 10'b0011111010. This holds both for direct mode with the strobe low and for FIFO mode with the FIFO empty.
- R5: With `fifo_bypass_i`=0, `fifo_rd_o` is high in exactly the cycles where `fifo_empty_i`=0 and `halt_i`=0. The word on `fifo_data_i` in that cycle (show-ahead FIFO) is the next slot's data, formed as in R2.
- R6: With `fifo_bypass_i`=1, `fifo_rd_o` stays 0 whatever `fifo_empty_i` is. With `fifo_bypass_i`=0, `data_en_i` and `data_i` have no effect on the output.
- R7: While `halt_i`=1, `fifo_rd_o` is 0 and the next slot is an idle of the kind set by `enc_bypass_i`, even when data is offered.
- R8: The raw-idle disparity toggle is held during data slots and encoder idle slots. The next raw idle continues the alternation.
- R9: With `fifo_bypass_i`=0, `enc_bypass_i`=0 and `fifo_empty_i`=1, the next slot is the encoder idle code (`ctrl_o`=1, `char_o`=0x0BC).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one character per cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_bypass_i | input | 1 | 1: take data from the direct port; 0: from the FIFO |
| enc_bypass_i | input | 1 | 1: encoder off, raw 10-bit characters |
| data_en_i | input | 1 | Direct-port data valid in this slot |
| data_i | input | 10 | Direct-port character |
| fifo_empty_i | input | 1 | FIFO holds no word |
| fifo_data_i | input | 10 | FIFO head word (show-ahead) |
| halt_i | input | 1 | Stop reading and send idle fill |
| fifo_rd_o | output | 1 | FIFO read strobe, one per character taken |
| char_o | output | 10 | Character for the encoder or serializer |
| ctrl_o | output | 1 | Encoder control flag: special character |

## Verification
The hardest case to reach is the disparity toggle surviving a long detour. Raw idles are interrupted by direct data, by encoder idles, by FIFO data and by a halt, and then resume. The alternation must continue from the held phase rather than restart or skip. The stimulus gets there in stages. It runs an odd number of raw idles so the toggle sits at the positive phase. It then switches straps and sends data and encoder idles. Finally it returns to encoder bypass in the other data-source mode. The scoreboard's own phase model predicts the exact symbol expected there.

// File: rtl/txfill_pkg.sv
package txfill_pkg;

    // Character width on the line side of an 8b/10b code
    localparam int CHAR_W = 10;

    // K28.5 pre-encoded forms; the positive form is the bitwise complement
    localparam logic [CHAR_W-1:0] IDLE_RD_NEG = 10'b0011111010;
    localparam logic [CHAR_W-1:0] IDLE_RD_POS = ~IDLE_RD_NEG;

    // Kind of character held in the output slot
    typedef enum logic [2:0] {
        SL_QUIET    = 3'd0,
        SL_DIRECT   = 3'd1,
        SL_QUEUE    = 3'd2,
        SL_K_IDLE   = 3'd3,
        SL_RAW_IDLE = 3'd4
    } slot_e;

endpackage

// File: rtl/txfill_slot_sel.sv
module txfill_slot_sel
    import txfill_pkg::*;
(
    input  logic  fifo_bypass_i,
    input  logic  enc_bypass_i,
    input  logic  data_en_i,
    input  logic  fifo_empty_i,
    input  logic  halt_i,
    output slot_e next_slot_o,
    output logic  fifo_rd_o
);

    slot_e idle_kind;

    always_comb begin
        idle_kind = enc_bypass_i ? SL_RAW_IDLE : SL_K_IDLE;
        fifo_rd_o = 1'b0;
        if (halt_i) begin
            next_slot_o = idle_kind;
        end else if (fifo_bypass_i) begin
            next_slot_o = data_en_i ? SL_DIRECT : idle_kind;
        end else if (!fifo_empty_i) begin
            next_slot_o = SL_QUEUE;
            fifo_rd_o   = 1'b1;
        end else begin
            next_slot_o = idle_kind;
        end
    end

endmodule

// File: rtl/txfill_disp.sv
module txfill_disp (
    input  logic clk,
    input  logic rst_n,
    input  logic advance_i,
    output logic rd_pos_o
);

    logic rd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         rd_q <= 1'b0;
        else if (advance_i) rd_q <= ~rd_q;
    end

    assign rd_pos_o = rd_q;

    // R8: phase is frozen whenever the slot is not a raw idle
    p_disp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !advance_i |=> $stable(rd_q));

    // R4: every raw idle slot moves the phase on
    p_disp_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        advance_i |=> (rd_q != $past(rd_q)));

endmodule

// File: rtl/txfill_slot_reg.sv
module txfill_slot_reg
    import txfill_pkg::*;
#(
    parameter int          BYTE_W  = 8,
    parameter logic [7:0]  K_INDEX = 8'hBC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  slot_e             next_slot_i,
    input  logic              enc_bypass_i,
    input  logic [CHAR_W-1:0] data_i,
    input  logic [CHAR_W-1:0] fifo_data_i,
    input  logic              rd_pos_i,
    output slot_e             slot_o,
    output logic [CHAR_W-1:0] char_o,
    output logic              ctrl_o
);

    localparam int PAD_W = CHAR_W - BYTE_W;

    slot_e             slot_q;
    logic [CHAR_W-1:0] word_q;
    logic [CHAR_W-1:0] src_word;

    // Pick the data source and form the character as it will be sent
    always_comb begin
        src_word = (next_slot_i == SL_QUEUE) ? fifo_data_i : data_i;
        if (!enc_bypass_i)
            src_word = {{PAD_W{1'b0}}, src_word[BYTE_W-1:0]};
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= SL_QUIET;
            word_q <= '0;
        end else begin
            slot_q <= next_slot_i;
            if (next_slot_i == SL_DIRECT || next_slot_i == SL_QUEUE)
                word_q <= src_word;
        end
    end

    // Output process
    always_comb begin
        char_o = '0;
        ctrl_o = 1'b0;
        unique case (slot_q)
            SL_QUIET:    char_o = '0;
            SL_DIRECT,
            SL_QUEUE:    char_o = word_q;
            SL_K_IDLE: begin
                char_o = {{PAD_W{1'b0}}, K_INDEX[BYTE_W-1:0]};
                ctrl_o = 1'b1;
            end
            SL_RAW_IDLE: char_o = rd_pos_i ? IDLE_RD_POS : IDLE_RD_NEG;
            default:     char_o = '0;
        endcase
    end

    assign slot_o = slot_q;

    // R4: consecutive raw idles never repeat the same symbol
    p_raw_alternate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q == SL_RAW_IDLE) && (next_slot_i == SL_RAW_IDLE)
            |=> (char_o != $past(char_o)));

endmodule

// File: rtl/txfill_ctrl.sv
module txfill_ctrl
    import txfill_pkg::*;
#(
    parameter int         BYTE_W  = 8,
    parameter logic [7:0] K_INDEX = 8'hBC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_bypass_i,
    input  logic              enc_bypass_i,
    input  logic              data_en_i,
    input  logic [CHAR_W-1:0] data_i,
    input  logic              fifo_empty_i,
    input  logic [CHAR_W-1:0] fifo_data_i,
    input  logic              halt_i,
    output logic              fifo_rd_o,
    output logic [CHAR_W-1:0] char_o,
    output logic              ctrl_o
);

    slot_e next_slot;
    slot_e slot_cur;
    logic  rd_pos;

    txfill_slot_sel u_sel (
        .fifo_bypass_i (fifo_bypass_i),
        .enc_bypass_i  (enc_bypass_i),
        .data_en_i     (data_en_i),
        .fifo_empty_i  (fifo_empty_i),
        .halt_i        (halt_i),
        .next_slot_o   (next_slot),
        .fifo_rd_o     (fifo_rd_o)
    );

    txfill_slot_reg #(
        .BYTE_W  (BYTE_W),
        .K_INDEX (K_INDEX)
    ) u_reg (
        .clk          (clk),
        .rst_n        (rst_n),
        .next_slot_i  (next_slot),
        .enc_bypass_i (enc_bypass_i),
        .data_i       (data_i),
        .fifo_data_i  (fifo_data_i),
        .rd_pos_i     (rd_pos),
        .slot_o       (slot_cur),
        .char_o       (char_o),
        .ctrl_o       (ctrl_o)
    );

    txfill_disp u_disp (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance_i (slot_cur == SL_RAW_IDLE),
        .rd_pos_o  (rd_pos)
    );

    // R5: a read delivers the head word in the following slot
    p_read_shows_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd_o |=> (!ctrl_o && char_o == ($past(enc_bypass_i) ? $past(fifo_data_i)
                       : {2'b00, $past(fifo_data_i[7:0])})));

    // R6: no reads while the FIFO is bypassed
    p_bypass_no_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_bypass_i |-> !fifo_rd_o);

    // R7: halt blocks reads and forces idle fill
    p_halt_no_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        halt_i |-> !fifo_rd_o);

    p_halt_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        halt_i |=> (ctrl_o || char_o == IDLE_RD_NEG || char_o == IDLE_RD_POS));

    // R3: the control flag always carries the special index
    p_kcode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_o |-> (char_o == {2'b00, K_INDEX}));

endmodule

// File: tb/tb_txfill_ctrl.sv
module tb_txfill_ctrl;

    localparam logic [9:0] RD_NEG = 10'b0011111010;
    localparam logic [9:0] RD_POS = 10'b1100000101;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_bypass_i = 1'b1;
    logic       enc_bypass_i = 1'b0;
    logic       data_en_i = 1'b0;
    logic [9:0] data_i = '0;
    logic       fifo_empty_i = 1'b1;
    logic [9:0] fifo_data_i = '0;
    logic       halt_i = 1'b0;
    logic       fifo_rd_o;
    logic [9:0] char_o;
    logic       ctrl_o;

    int errors = 0;
    int checks = 0;
    logic exp_rd = 1'b0;
    logic [10:0] exp_q[$];
    string       tag_q[$];
    bit          done = 1'b0;

    always #2 clk = ~clk;

    txfill_ctrl dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .fifo_bypass_i (fifo_bypass_i),
        .enc_bypass_i  (enc_bypass_i),
        .data_en_i     (data_en_i),
        .data_i        (data_i),
        .fifo_empty_i  (fifo_empty_i),
        .fifo_data_i   (fifo_data_i),
        .halt_i        (halt_i),
        .fifo_rd_o     (fifo_rd_o),
        .char_o        (char_o),
        .ctrl_o        (ctrl_o)
    );

    task automatic check(input string tag, input logic [10:0] act, input logic [10:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: sets one slot's inputs, predicts the result, pushes it
    task automatic drive(input logic fb, input logic eb, input logic en,
                         input logic [9:0] d, input logic emp,
                         input logic [9:0] fd, input logic hl, input string tag);
        logic [10:0] v;
        logic [9:0]  w;
        logic        rd_exp;
        @(negedge clk);
        fifo_bypass_i = fb; enc_bypass_i = eb; data_en_i = en; data_i = d;
        fifo_empty_i = emp; fifo_data_i = fd; halt_i = hl;
        rd_exp = !hl && !fb && !emp;
        if (hl || (fb && !en) || (!fb && emp)) begin
            if (eb) begin
                v = {1'b0, exp_rd ? RD_POS : RD_NEG};
                exp_rd = ~exp_rd;
            end else begin
                v = {1'b1, 2'b00, 8'hBC};
            end
        end else begin
            w = fb ? d : fd;
            v = {1'b0, eb ? w : {2'b00, w[7:0]}};
        end
        exp_q.push_back(v);
        tag_q.push_back(tag);
        #1;
        check({tag, " rd"}, {10'b0, fifo_rd_o}, {10'b0, rd_exp});
    endtask

    // Monitor: compare output after each edge with the scoreboard head
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [10:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {ctrl_o, char_o}, e);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset held", {ctrl_o, char_o}, 11'd0);
        rst_n = 1'b1;
        #1;
        check("R1 after release", {ctrl_o, char_o}, 11'd0);

        // Direct mode, encoder on
        drive(1, 0, 1, 10'h35A, 1, 10'h000, 0, "R2 direct byte");
        drive(1, 0, 1, 10'h0A5, 0, 10'h3FF, 0, "R2 direct byte b / R6");
        drive(1, 0, 0, 10'h3C3, 0, 10'h3FF, 0, "R3 direct idle");
        drive(1, 0, 1, 10'h13C, 1, 10'h000, 0, "R2 direct c");
        // Direct mode, encoder bypassed
        drive(1, 1, 0, 10'h000, 1, 10'h000, 0, "R4 raw first neg");
        drive(1, 1, 0, 10'h000, 1, 10'h000, 0, "R4 raw pos");
        drive(1, 1, 0, 10'h000, 1, 10'h000, 0, "R4 raw neg");
        drive(1, 1, 1, 10'h2AB, 1, 10'h000, 0, "R2 raw data full width");
        drive(1, 1, 0, 10'h000, 1, 10'h000, 0, "R8 raw after data");
        // Encoder idles between raw idles
        drive(1, 0, 0, 10'h000, 1, 10'h000, 0, "R3 k idle");
        drive(1, 0, 0, 10'h000, 1, 10'h000, 0, "R3 k idle again");
        drive(1, 1, 0, 10'h000, 1, 10'h000, 0, "R8 raw after k idles");
        // FIFO mode, encoder on
        drive(0, 0, 0, 10'h000, 0, 10'h311, 0, "R5 fifo read");
        drive(0, 0, 1, 10'h0EE, 0, 10'h022, 0, "R6 strobe ignored");
        drive(0, 0, 1, 10'h0EE, 1, 10'h033, 0, "R9 empty idle");
        drive(0, 0, 1, 10'h0EE, 0, 10'h044, 1, "R7 halt fifo");
        drive(0, 0, 0, 10'h000, 0, 10'h055, 0, "R5 read after halt");
        // FIFO mode, encoder bypassed
        drive(0, 1, 0, 10'h000, 1, 10'h000, 0, "R4 fifo empty raw");
        drive(0, 1, 0, 10'h000, 1, 10'h000, 0, "R4 fifo empty raw 2");
        drive(0, 1, 1, 10'h1FF, 0, 10'h2C7, 0, "R5 fifo raw word");
        drive(0, 1, 0, 10'h000, 0, 10'h155, 1, "R7 halt raw");
        drive(0, 1, 0, 10'h000, 0, 10'h0F0, 0, "R8 fifo word");
        drive(0, 1, 0, 10'h000, 1, 10'h000, 0, "R8 raw resume");
        // Halt in direct mode
        drive(1, 0, 1, 10'h077, 0, 10'h000, 1, "R7 halt direct");
        drive(1, 1, 1, 10'h077, 0, 10'h000, 1, "R7 halt direct raw");
        drive(1, 0, 1, 10'h066, 0, 10'h000, 0, "R2 direct after halt");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule